// File: doc/BRIEF.md
# PLL Lock Monitor with Feedback Watchdog

This block reports whether a phase-locked loop is holding lock. The reference clock and the feedback clock enter asynchronously. Each one is brought into a fast system clock domain, where its rising edges are detected. Every feedback rising edge is scored as clean or as a phase error. The score depends on how many system cycles have passed since the most recent reference rising edge, compared against a programmable window.

The lock flag has asymmetric hysteresis. Once set, it survives short bursts of errors and falls only after four errors in a row. Once cleared, it returns only after thirty-two clean feedback cycles in a row. A separate watchdog covers a feedback clock that has stopped entirely. The watchdog counts ticks of a divided-down reference clock and forces the flag low if no feedback edge arrives within a programmable number of ticks. If the reference clock itself is idle, the flag carries no meaning.

The block has no data stream. All pins are plain control and status levels.

Top module: `pll_lock_mon`

## Requirements
- R1: After reset, `lock_o` is low and the error-run and clean-run counters are both zero.
- R2: Both clock inputs pass through identical two-flop synchronizers, followed by rising-edge detection. A feedback verdict therefore depends only on the separation in system cycles between the input rising transitions. `lock_o` reacts four system cycles after the feedback input rises.
- R3: The separation of a feedback edge is the number of system cycles since the latest reference edge, counted from 1. A feedback edge arriving in the same cycle as a reference edge has separation 0. A separation up to and including `win_cycles_i` is clean, and a larger one is a phase error.
- R4: A feedback edge with no reference edge since the previous feedback edge is a phase error.
- R5: While locked, the 4th consecutive phase error (parameter DROP_RUN) drives `lock_o` low. Three consecutive errors leave it high.
- R6: While unlocked, the 32nd consecutive clean feedback cycle (parameter RISE_RUN) drives `lock_o` high. Thirty-one clean cycles leave it low.
- R7: A clean cycle clears the error run, and an error cycle clears the clean run.
- R8: The watchdog produces one tick every max(`ref_div_i`,1) reference edges. Its count restarts on every feedback edge. It expires once max(`wd_limit_i`,1) ticks have accumulated.
- R9: While the watchdog is expired, `lock_o` is forced low and the clean run is held at zero. Lock can be regained only through a new full run of clean cycles.
- R10: `lock_o` changes only as the result of a feedback verdict, a watchdog expiry, or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must be much faster than both monitored clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Reference clock, asynchronous |
| fb_clk_i | input | 1 | Feedback clock, asynchronous |
| win_cycles_i | input | WIN_W | Largest separation, in system cycles, still judged clean |
| ref_div_i | input | DIV_W | Reference edges per watchdog tick (0 acts as 1) |
| wd_limit_i | input | WD_W | Watchdog ticks without a feedback edge before expiry (0 acts as 1) |
| lock_o | output | 1 | Lock status flag |

## Verification
The hardest state to reach from the ports is a watchdog expiry that interrupts a locked loop and is then followed by recovery. The bench reaches it in three steps. First it keeps the reference running with feedback silent, for fewer periods than the time-out, and checks that lock holds. Then it extends the silence past the time-out. Finally it resumes feedback, and checks that 31 clean cycles are not enough to regain lock while the 32nd is. Run boundaries are reached by alternating runs of exact length: one short of the threshold, then at the threshold, with a single opposite verdict inserted to show that the run was reset.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

  // Verdict for one feedback edge, registered in the phase comparator.
  typedef struct packed {
    logic tick;  // a feedback edge was judged this cycle
    logic err;   // that edge was a phase error
  } phase_res_t;

  // Saturating increment against a ceiling value.
  function automatic logic [15:0] sat_inc16(input logic [15:0] v, input logic [15:0] ceil);
    return (v >= ceil) ? ceil : v + 16'd1;
  endfunction

endpackage

// File: rtl/ld_edge_sync.sv
module ld_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  // sh[0..STAGES-1] form the synchronizer; sh[STAGES] holds the previous level.
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], async_i};
  end

  assign rise_o = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/ld_phase_cmp.sv
module ld_phase_cmp
  import lockdet_pkg::*;
#(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_rise_i,
  input  logic             fb_rise_i,
  input  logic [WIN_W-1:0] win_i,
  output phase_res_t       res_o
);
  localparam int EW = WIN_W + 1;
  localparam logic [EW-1:0] EL_MAX = '1;

  logic [EW-1:0] elapsed;
  logic          armed;
  logic          late;

  // An edge is late when no reference edge is pending or the gap exceeds the window.
  assign late = !armed || (elapsed > {1'b0, win_i});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed <= '0;
      armed   <= 1'b0;
      res_o   <= '0;
    end else begin
      if (ref_rise_i) begin
        elapsed <= EW'(1);
        armed   <= !fb_rise_i;   // a coincident feedback edge consumes this reference edge
      end else begin
        if (armed && elapsed != EL_MAX) elapsed <= elapsed + EW'(1);
        if (fb_rise_i) armed <= 1'b0;
      end
      res_o.tick <= fb_rise_i;
      res_o.err  <= fb_rise_i && !ref_rise_i && late;
    end
  end
endmodule

// File: rtl/ld_run_filter.sv
module ld_run_filter
  import lockdet_pkg::*;
#(
  parameter int DROP_RUN = 4,
  parameter int RISE_RUN = 32,
  parameter int EW = $clog2(DROP_RUN + 1),
  parameter int CW = $clog2(RISE_RUN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_res_t    res_i,
  input  logic          expired_i,
  output logic          lock_o,
  output logic [EW-1:0] err_run_o,
  output logic [CW-1:0] clean_run_o
);
  localparam logic [EW-1:0] DROP_CEIL = EW'(DROP_RUN);
  localparam logic [CW-1:0] RISE_CEIL = CW'(RISE_RUN);
  localparam logic [EW-1:0] DROP_LAST = EW'(DROP_RUN - 1);
  localparam logic [CW-1:0] RISE_LAST = CW'(RISE_RUN - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_o      <= 1'b0;
      err_run_o   <= '0;
      clean_run_o <= '0;
    end else if (expired_i) begin
      lock_o      <= 1'b0;
      err_run_o   <= '0;
      clean_run_o <= '0;
    end else if (res_i.tick) begin
      if (res_i.err) begin
        clean_run_o <= '0;
        err_run_o   <= EW'(sat_inc16(16'(err_run_o), 16'(DROP_CEIL)));
        if (err_run_o >= DROP_LAST) lock_o <= 1'b0;
      end else begin
        err_run_o   <= '0;
        clean_run_o <= CW'(sat_inc16(16'(clean_run_o), 16'(RISE_CEIL)));
        if (clean_run_o >= RISE_LAST) lock_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ld_watchdog.sv
module ld_watchdog #(
  parameter int DIV_W = 8,
  parameter int WD_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_rise_i,
  input  logic             fb_rise_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [WD_W-1:0]  limit_i,
  output logic             expired_o
);
  logic [DIV_W-1:0] pcnt;
  logic [DIV_W-1:0] div_last;
  logic [WD_W-1:0]  lim_eff;
  logic [WD_W-1:0]  wd_cnt;
  logic             tick;

  assign div_last = (div_i == '0) ? '0 : div_i - DIV_W'(1);
  assign lim_eff  = (limit_i == '0) ? WD_W'(1) : limit_i;
  assign tick     = ref_rise_i && (pcnt >= div_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt   <= '0;
      wd_cnt <= '0;
    end else begin
      if (ref_rise_i) pcnt <= tick ? '0 : pcnt + DIV_W'(1);
      if (fb_rise_i)                      wd_cnt <= '0;
      else if (tick && wd_cnt < lim_eff)  wd_cnt <= wd_cnt + WD_W'(1);
    end
  end

  assign expired_o = (wd_cnt >= lim_eff);
endmodule

// File: rtl/pll_lock_mon.sv
module pll_lock_mon
  import lockdet_pkg::*;
#(
  parameter int WIN_W    = 8,
  parameter int DIV_W    = 8,
  parameter int WD_W     = 8,
  parameter int DROP_RUN = 4,
  parameter int RISE_RUN = 32,
  parameter int STAGES   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_clk_i,
  input  logic             fb_clk_i,
  input  logic [WIN_W-1:0] win_cycles_i,
  input  logic [DIV_W-1:0] ref_div_i,
  input  logic [WD_W-1:0]  wd_limit_i,
  output logic             lock_o
);
  localparam int EW = $clog2(DROP_RUN + 1);
  localparam int CW = $clog2(RISE_RUN + 1);

  logic [1:0]    clk_in;
  logic [1:0]    rise;
  phase_res_t    ph_res;
  logic          ph_tick, ph_err;
  logic          wd_expired;
  logic [EW-1:0] err_run;
  logic [CW-1:0] clean_run;

  assign clk_in = {fb_clk_i, ref_clk_i};

  // Identical synchronizer per monitored clock: index 0 reference, 1 feedback.
  for (genvar g = 0; g < 2; g++) begin : g_sync
    ld_edge_sync #(.STAGES(STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_i(clk_in[g]), .rise_o(rise[g])
    );
  end

  ld_phase_cmp #(.WIN_W(WIN_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .ref_rise_i(rise[0]), .fb_rise_i(rise[1]),
    .win_i(win_cycles_i), .res_o(ph_res)
  );

  assign ph_tick = ph_res.tick;
  assign ph_err  = ph_res.err;

  ld_watchdog #(.DIV_W(DIV_W), .WD_W(WD_W)) u_wd (
    .clk(clk), .rst_n(rst_n), .ref_rise_i(rise[0]), .fb_rise_i(rise[1]),
    .div_i(ref_div_i), .limit_i(wd_limit_i), .expired_o(wd_expired)
  );

  ld_run_filter #(.DROP_RUN(DROP_RUN), .RISE_RUN(RISE_RUN), .EW(EW), .CW(CW)) u_filt (
    .clk(clk), .rst_n(rst_n), .res_i(ph_res), .expired_i(wd_expired),
    .lock_o(lock_o), .err_run_o(err_run), .clean_run_o(clean_run)
  );
endmodule

// File: rtl/ld_lock_checker.sv
module ld_lock_checker #(
  parameter int DROP_RUN = 4,
  parameter int RISE_RUN = 32,
  parameter int EW = 3,
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lock_o,
  input logic          fb_rise,
  input logic          ph_tick,
  input logic          ph_err,
  input logic          wd_expired,
  input logic [EW-1:0] err_run,
  input logic [CW-1:0] clean_run
);
  AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(ph_tick && !ph_err && !wd_expired)); // R6

  AST_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_o) |-> $past((ph_tick && ph_err) || wd_expired)); // R10

  AST_EXPIRY_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expired |=> !lock_o); // R9

  AST_LOCKED_ERR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o |-> (32'(err_run) < DROP_RUN)); // R5

  AST_UNLOCKED_CLEAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_o |-> (32'(clean_run) < RISE_RUN)); // R6

  AST_RUNS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !((err_run != '0) && (clean_run != '0))); // R7

  AST_VERDICT_FOLLOWS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ph_tick |-> $past(fb_rise)); // R2
endmodule

bind pll_lock_mon ld_lock_checker #(
  .DROP_RUN(DROP_RUN), .RISE_RUN(RISE_RUN), .EW(EW), .CW(CW)
) u_lock_chk (
  .clk(clk), .rst_n(rst_n), .lock_o(lock_o), .fb_rise(rise[1]),
  .ph_tick(ph_tick), .ph_err(ph_err), .wd_expired(wd_expired),
  .err_run(err_run), .clean_run(clean_run)
);

// File: tb/test_pll_lock_mon.sv
module test_pll_lock_mon;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_clk = 1'b0;
  logic       fb_clk = 1'b0;
  logic [7:0] win = 8'd4;
  logic [7:0] rdiv = 8'd2;
  logic [7:0] wlim = 8'd3;
  logic       lock;

  int n_chk = 0;
  int n_fail = 0;

  localparam int PERIOD = 16;  // system cycles per reference period
  localparam int NV = 17;
  // {periods, feedback offset (-1 = no feedback), expected lock, requirement}
  localparam int VEC[NV][4] = '{
    '{31, 2, 0, 6},   // R6 one short of the clean run
    '{ 1, 2, 1, 6},   // R6 32nd clean cycle
    '{ 3, 8, 1, 5},   // R5 three errors keep lock
    '{ 1, 8, 0, 5},   // R5 fourth error drops
    '{20, 4, 0, 3},   // R3 offset equal to window is clean
    '{ 1, 5, 0, 7},   // R7 one error clears clean run
    '{31, 4, 0, 7},   // R7 new run starts from zero
    '{ 1, 0, 1, 3},   // R3 coincident edges are clean; R2
    '{ 3, 9, 1, 5},
    '{ 1, 1, 1, 7},   // R7 clean cycle clears error run
    '{ 3, 9, 1, 7},
    '{ 1, 9, 0, 5},
    '{32, 3, 1, 6},
    '{ 2,-1, 1, 8},   // R8 silence shorter than time-out
    '{ 6,-1, 0, 8},   // R8 expiry drops lock
    '{31, 2, 0, 9},   // R9 clean run restarted by expiry
    '{ 1, 2, 1, 9}
  };

  pll_lock_mon i_pll_lock_mon (
    .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_clk), .fb_clk_i(fb_clk),
    .win_cycles_i(win), .ref_div_i(rdiv), .wd_limit_i(wlim), .lock_o(lock)
  );

  always #10ns clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s lock_o=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // Drive reference periods; feedback rises 'sep' cycles after the reference.
  task automatic periods(input int n, input int sep);
    for (int p = 0; p < n; p++) begin
      for (int c = 0; c < PERIOD; c++) begin
        @(negedge clk);
        ref_clk = (c < PERIOD/2);
        fb_clk  = (sep >= 0) && (c >= sep) && (c < sep + 4);
      end
    end
  endtask

  task automatic finish_run;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20ns * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired before completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", lock, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", lock, 1'b0);

    for (int v = 0; v < NV; v++) begin
      periods(VEC[v][0], VEC[v][1]);
      chk($sformatf("R%0d vector %0d", VEC[v][3], v), lock, VEC[v][2] != 0);
    end

    // R3: a wider window accepts offset 7, a narrower one rejects offset 3
    win = 8'd8;
    periods(4, 7);
    chk("R3 wide window", lock, 1'b1);
    win = 8'd2;
    periods(4, 3);
    chk("R3 narrow window", lock, 1'b0);

    // R4: a second feedback edge with no reference edge between is an error
    win = 8'd4;
    periods(32, 2);
    chk("R4 relock", lock, 1'b1);
    for (int k = 0; k < 4; k++) begin
      for (int c = 0; c < PERIOD; c++) begin
        @(negedge clk);
        ref_clk = (k == 0) && (c < PERIOD/2);
        fb_clk  = ((c >= 2) && (c < 5)) || ((c >= 9) && (c < 12));
      end
    end
    chk("R4 unarmed feedback edges", lock, 1'b0);

    // R1: reset in the middle of a locked run clears lock and the clean run
    periods(32, 2);
    chk("R1 locked before reset", lock, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-run reset", lock, 1'b0);
    rst_n = 1'b1;
    periods(31, 2);
    chk("R1 clean run restarted", lock, 1'b0);

    finish_run();
  end
endmodule